// File: doc/BRIEF.md
# Two-Phase Latch Counter

This block is a binary up counter whose state is held in level-sensitive latches, not in edge-triggered flops. The state sits in two latch ranks. The hold rank is open while the first phase is high, and it copies the step rank. The step rank is open while the second phase is high, and it loads the hold rank plus one. Because each rank reads only the other rank, and the two phases are never high together, every pass through first phase then second phase moves the count forward by exactly one.

The count is the hold rank's value. The step rank is also brought out, so the next value can be seen. An asynchronous reset clears both ranks. The width is a parameter (default 3 bits). The increment is a ripple chain: each bit flips when all lower bits of the hold rank are one.

The two phases are plain control pins, not a stream. There is no valid/ready handshake and no back-pressure: the count advances whenever the phase pair is applied. The phases themselves come from outside the block.

Top module: `twophase_latch_counter`

## Requirements
- R1: While `rst` is high, `count` and `next_count` are 0 at once, without any phase activity, and phase pulses during reset change nothing.
- R2: While `phi_a` is high, `count` follows `next_count`; while `phi_a` is low, `count` holds its value.
- R3: While `phi_b` is high, `next_count` equals `count` + 1 modulo 2^WIDTH (bit i is count bit i XOR the AND of count bits below i; bit 0 is the inverse of count bit 0); while `phi_b` is low, `next_count` holds its value.
- R4: After k pairs of (`phi_a` pulse, then `phi_b` pulse) counted from reset, `count` equals k-1 and `next_count` equals k, both modulo 2^WIDTH.
- R5: The count wraps from all ones (7 at the default width) to 0 with no stall.
- R6: Repeated `phi_b` pulses with no `phi_a` pulse between them do not advance the state, and repeated `phi_a` pulses with no `phi_b` pulse between them do not advance it either.
- R7: `phi_a` and `phi_b` are never high at the same time; an overlap is a protocol violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phi_a | input | 1 | First phase; opens the hold rank |
| phi_b | input | 1 | Second phase; opens the step rank |
| rst | input | 1 | Asynchronous reset, active high; clears both ranks |
| count | output | WIDTH | Hold rank value (the counter output) |
| next_count | output | WIDTH | Step rank value (next count) |

## Verification
Four properties are checked at every phase edge. The phases must not overlap. At the end of a first-phase window the hold rank must equal the step rank. At the end of a second-phase window the step rank must equal the hold rank plus one. Other behaviour can only be shown by the bench's scenarios: the asynchronous clear during a running count, the k-1/k relation over many phase pairs, the wrap through zero, and the fact that repeated single-phase pulses do not advance the count.

// File: rtl/tpl_pkg.sv
package tpl_pkg;
  localparam int unsigned DEFAULT_WIDTH = 3;
endpackage

// File: rtl/tpl_hold_rank.sv
// Hold rank: transparent while phi_a is high, copies the step rank.
module tpl_hold_rank #(
  parameter int unsigned WIDTH = tpl_pkg::DEFAULT_WIDTH
) (
  input  logic             phi_a,
  input  logic             rst,
  input  logic [WIDTH-1:0] step_q,
  output logic [WIDTH-1:0] hold_q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_latch begin
      if (rst)        hold_q[i] <= 1'b0;
      else if (phi_a) hold_q[i] <= step_q[i];
    end
  end

  // R2: at the close of the first-phase window, hold equals step
  a_r2_hold_tracks_step: assert property (@(negedge phi_a) disable iff (rst)
    hold_q == step_q);
endmodule

// File: rtl/tpl_step_rank.sv
// Step rank: transparent while phi_b is high, loads hold + 1 via ripple carry.
module tpl_step_rank #(
  parameter int unsigned WIDTH = tpl_pkg::DEFAULT_WIDTH
) (
  input  logic             phi_b,
  input  logic             rst,
  input  logic [WIDTH-1:0] hold_q,
  output logic [WIDTH-1:0] step_q
);
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] inc_d;

  assign carry[0] = 1'b1;
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign inc_d[i]    = hold_q[i] ^ carry[i];
    assign carry[i+1]  = hold_q[i] & carry[i];
    always_latch begin
      if (rst)        step_q[i] <= 1'b0;
      else if (phi_b) step_q[i] <= inc_d[i];
    end
  end

  // R3: at the close of the second-phase window, step equals hold plus one
  a_r3_step_is_increment: assert property (@(negedge phi_b) disable iff (rst)
    step_q == WIDTH'(hold_q + 1'b1));
endmodule

// File: rtl/twophase_latch_counter.sv
module twophase_latch_counter #(
  parameter int unsigned WIDTH = tpl_pkg::DEFAULT_WIDTH
) (
  input  logic             phi_a,
  input  logic             phi_b,
  input  logic             rst,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] next_count
);
  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] step_q;

  tpl_hold_rank #(.WIDTH(WIDTH)) u_hold (
    .phi_a (phi_a),
    .rst   (rst),
    .step_q(step_q),
    .hold_q(hold_q)
  );

  tpl_step_rank #(.WIDTH(WIDTH)) u_step (
    .phi_b (phi_b),
    .rst   (rst),
    .hold_q(hold_q),
    .step_q(step_q)
  );

  assign count      = hold_q;
  assign next_count = step_q;

  // R7: the phases never overlap
  a_r7_no_overlap_a: assert property (@(posedge phi_a) disable iff (rst) !phi_b);
  a_r7_no_overlap_b: assert property (@(posedge phi_b) disable iff (rst) !phi_a);
endmodule

// File: tb/tb_twophase_latch_counter.sv
module tb_twophase_latch_counter;
  localparam int W = 3;
  localparam int CLK_PERIOD = 20;
  localparam int PH = CLK_PERIOD / 4;

  logic phi_a, phi_b, rst;
  logic [W-1:0] count, next_count;
  int checks = 0, errors = 0;
  logic [W-1:0] exp_cnt, exp_nxt;
  logic [W-1:0] q_cnt[$];
  logic [W-1:0] q_nxt[$];
  bit done = 0;

  twophase_latch_counter #(.WIDTH(W)) dut (
    .phi_a(phi_a), .phi_b(phi_b), .rst(rst),
    .count(count), .next_count(next_count)
  );

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_a();
    phi_a = 1; #PH; phi_a = 0; #PH;
  endtask

  task automatic pulse_b();
    phi_b = 1; #PH; phi_b = 0; #PH;
  endtask

  // driver: one phase pair, pushing the expected state for the monitor
  task automatic tick();
    pulse_a();
    exp_cnt = exp_nxt;
    exp_nxt = W'(exp_cnt + 1);
    q_cnt.push_back(exp_cnt);
    q_nxt.push_back(exp_nxt);
    pulse_b();
  endtask

  // monitor: compares after each second-phase pulse (R4, R5)
  initial begin
    forever begin
      @(negedge phi_b);
      #1;
      if (q_cnt.size() != 0) begin
        check("R4 count after pair", count, q_cnt.pop_front());
        check("R4 next after pair", next_count, q_nxt.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 10000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    phi_a = 0; phi_b = 0; rst = 1;
    #PH;
    check("R1 reset count", count, 0);
    check("R1 reset next", next_count, 0);
    // R1: phases during reset are ignored
    pulse_a(); pulse_b(); pulse_a();
    check("R1 count in reset", count, 0);
    check("R1 next in reset", next_count, 0);
    rst = 0; #PH;
    exp_cnt = 0; exp_nxt = 0;

    // R4/R5: ten pairs, passing through the wrap
    for (int i = 0; i < 10; i++) tick();
    #1;
    check("R5 wrapped count", count, 1);   // after 10 pairs: 9 mod 8
    check("R5 wrapped next", next_count, 2);

    // R2: transparency while phi_a high
    phi_a = 1; #1;
    check("R2 count follows next", count, 2);
    #PH; phi_a = 0; #PH;
    check("R2 count holds low", count, 2);
    exp_cnt = 2;

    // R6: repeated phi_b without phi_a
    pulse_b(); pulse_b(); pulse_b(); #1;
    check("R6 repeated phi_b next", next_count, 3);
    check("R6 repeated phi_b count", count, 2);
    // R3: step rank holds while phi_b low
    check("R3 next holds", next_count, 3);
    // R6: repeated phi_a without phi_b
    pulse_a(); pulse_a(); pulse_a(); #1;
    check("R6 repeated phi_a count", count, 3);
    check("R6 repeated phi_a next", next_count, 3);
    exp_cnt = 3; exp_nxt = 3;

    // run to all ones and wrap again (R5)
    for (int i = 0; i < 5; i++) tick();
    #1;
    check("R5 second wrap count", count, 7);
    check("R5 second wrap next", next_count, 0);

    // R1: asynchronous clear mid-count, no phase activity
    rst = 1; #1;
    check("R1 async clear count", count, 0);
    check("R1 async clear next", next_count, 0);
    #PH; rst = 0; #PH;
    exp_cnt = 0; exp_nxt = 0;
    tick(); tick(); #1;
    check("R4 restart count", count, 1);

    // R7 is covered by the phase-overlap assertions during every pulse above
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule